// File: doc/BRIEF.md
# Saturating Add/Subtract with Doubling

This block adds or subtracts two signed 32-bit operands and clamps the answer to the signed 32-bit range instead of letting it wrap. Two further operations double the second operand first. The doubling is itself clamped, and the clamped value is then added to or subtracted from the first operand, with a second clamp on the final answer.

An operation is taken when the valid strobe is high. Its result is registered and held until the next valid operation. Any clamp raises a sticky saturation flag. The flag sits at bit 27 of a 32-bit status word and stays set until a synchronous clear. In the doubling operations, a clamp in either step counts.

Top module: `sat_arith`

## Requirements
- R1: With op_i = 2'b00, the registered result is opa_i + opb_i as signed values, clamped to 32'h7FFFFFFF or 32'h80000000 when it leaves the signed 32-bit range.
- R2: With op_i = 2'b01, the registered result is opa_i - opb_i, clamped to the same range.
- R3: With op_i = 2'b10, opb_i is doubled and clamped, and the clamped value is added to opa_i with a second clamp.
- R4: With op_i = 2'b11, opb_i is doubled and clamped, and the clamped value is subtracted from opa_i with a second clamp.
- R5: A valid operation sets status_o bit 27 whenever any of its clamps took effect. This includes a doubling operation whose first-step clamp was followed by an in-range final sum.
- R6: Status bit 27 is sticky. Valid operations that do not clamp leave it set.
- R7: clr_i clears bit 27 at the next clock edge. When clr_i and valid_i are both high, bit 27 takes only that operation's saturation indication.
- R8: While valid_i is low, res_o holds its value and the flag changes only through clr_i.
- R9: An active-low asynchronous reset sets res_o and status_o to zero.
- R10: All status_o bits other than bit 27 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Takes an operation at this clock edge |
| op_i | input | 2 | 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| opa_i | input | 32 | First signed operand |
| opb_i | input | 32 | Second signed operand |
| clr_i | input | 1 | Synchronous clear of the saturation flag |
| res_o | output | 32 | Registered clamped result |
| status_o | output | 32 | Status word, sticky saturation flag at bit 27 |

## Verification
The directed operands are chosen to tell apart three cases: a clamp on the positive side, a clamp on the negative side, and a result that lands exactly on a limit without clamping. The doubling operations are given operands where only the doubling step clamps, where only the final step clamps, and where neither does. This separates the ORed flag from a flag that tracks only the final sum. Random operands are drawn with a bias toward the extreme values and mixed with occasional clears and idle cycles. This exercises stickiness, the clear-versus-operation priority, and result hold.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;
endpackage

// File: rtl/sat_clamp.sv
module sat_clamp #(
  parameter int DATA_W = 32,
  parameter int EXT_W  = DATA_W + 2
) (
  input  logic [EXT_W-1:0]  x_i,
  output logic [DATA_W-1:0] y_o,
  output logic              sat_o
);
  localparam int TOP_N = EXT_W - DATA_W + 1;
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [TOP_N-1:0] top_bits;
  assign top_bits = x_i[EXT_W-1:DATA_W-1];

  // in range iff all bits above the result sign match it
  always_comb begin
    sat_o = !((&top_bits) || !(|top_bits));
    if (sat_o) y_o = x_i[EXT_W-1] ? MIN_V : MAX_V;
    else       y_o = x_i[DATA_W-1:0];
  end
endmodule

// File: rtl/sat_core.sv
module sat_core
  import sat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  sat_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  localparam int EXT_W = DATA_W + 2;

  logic             dbl_en, sub_en;
  logic [EXT_W-1:0] b_ext, a_ext, sec_ext, dbl_raw, fin_raw;
  logic [DATA_W-1:0] dbl_val, sec_val;
  logic             dbl_sat, fin_sat;

  always_comb begin
    dbl_en = 1'b0;
    sub_en = 1'b0;
    unique case (op_i)
      OP_ADD:  begin dbl_en = 1'b0; sub_en = 1'b0; end
      OP_SUB:  begin dbl_en = 1'b0; sub_en = 1'b1; end
      OP_DADD: begin dbl_en = 1'b1; sub_en = 1'b0; end
      OP_DSUB: begin dbl_en = 1'b1; sub_en = 1'b1; end
      default: begin dbl_en = 1'b0; sub_en = 1'b0; end
    endcase
  end

  assign b_ext   = {{2{b_i[DATA_W-1]}}, b_i};
  assign a_ext   = {{2{a_i[DATA_W-1]}}, a_i};
  assign dbl_raw = b_ext + b_ext;

  sat_clamp #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_dbl_clamp (
    .x_i  (dbl_raw),
    .y_o  (dbl_val),
    .sat_o(dbl_sat)
  );

  assign sec_val = dbl_en ? dbl_val : b_i;
  assign sec_ext = {{2{sec_val[DATA_W-1]}}, sec_val};
  assign fin_raw = sub_en ? (a_ext - sec_ext) : (a_ext + sec_ext);

  sat_clamp #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_fin_clamp (
    .x_i  (fin_raw),
    .y_o  (res_o),
    .sat_o(fin_sat)
  );

  // either step clamping counts
  assign sat_o = fin_sat | (dbl_en & dbl_sat);
endmodule

// File: rtl/sat_status.sv
module sat_status #(
  parameter int STAT_W   = 32,
  parameter int FLAG_POS = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sat_i,
  input  logic              clr_i,
  output logic [STAT_W-1:0] status_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (clr_i)  flag_q <= valid_i & sat_i;
    else if (valid_i) flag_q <= flag_q | sat_i;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bits
    if (i == FLAG_POS) begin : g_flag
      assign status_o[i] = flag_q;
    end else begin : g_zero
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sat_arith.sv
module sat_arith
  import sat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FLAG_POS = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] res_d, res_q;
  logic              sat_d;

  sat_core #(.DATA_W(DATA_W)) u_core (
    .op_i (sat_op_e'(op_i)),
    .a_i  (opa_i),
    .b_i  (opb_i),
    .res_o(res_d),
    .sat_o(sat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      res_q <= '0;
    else if (valid_i) res_q <= res_d;
  end

  sat_status #(.STAT_W(DATA_W), .FLAG_POS(FLAG_POS)) u_status (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sat_i   (sat_d),
    .clr_i   (clr_i),
    .status_o(status_o)
  );

  assign res_o = res_q;
endmodule

// File: rtl/sat_arith_chk.sv
module sat_arith_chk #(
  parameter int DATA_W   = 32,
  parameter int FLAG_POS = 27
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic              clr_i,
  input logic [DATA_W-1:0] res_o,
  input logic [DATA_W-1:0] status_o
);
  localparam logic [DATA_W-1:0] OTHER_MASK = ~(DATA_W'(1) << FLAG_POS);

  // R1: opposite signs cannot overflow, result equals the plain sum
  a_r1_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b00 && opa_i[DATA_W-1] != opb_i[DATA_W-1])
    |=> res_o == $past(opa_i) + $past(opb_i));

  // R6: flag stays set without a clear
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[FLAG_POS] && !clr_i) |=> status_o[FLAG_POS]);

  // R7: clear without operation drops the flag
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !valid_i) |=> !status_o[FLAG_POS]);

  // R8: idle cycle holds the result
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));

  // R8: idle cycle without clear holds the flag
  a_r8_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clr_i) |=> $stable(status_o));

  // R10: only the flag bit may be set
  a_r10_other_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & OTHER_MASK) == '0);
endmodule

bind sat_arith sat_arith_chk #(.DATA_W(DATA_W), .FLAG_POS(FLAG_POS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .op_i    (op_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .clr_i   (clr_i),
  .res_o   (res_o),
  .status_o(status_o)
);

// File: tb/sat_arith_test.sv
`timescale 1ns/1ps
module sat_arith_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] opa_i = '0;
  logic [31:0] opb_i = '0;
  logic        clr_i = 1'b0;
  logic [31:0] res_o, status_o;

  int          checks = 0;
  int          fails  = 0;
  logic [31:0] exp_res  = '0;
  bit          exp_flag = 1'b0;
  bit          done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sat_arith uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .opa_i(opa_i), .opb_i(opb_i), .clr_i(clr_i),
    .res_o(res_o), .status_o(status_o)
  );

  function automatic logic [31:0] sat32(input longint x, output bit s);
    s = 1'b0;
    if (x > 64'sd2147483647) begin s = 1'b1; return 32'h7FFFFFFF; end
    if (x < -64'sd2147483648) begin s = 1'b1; return 32'h80000000; end
    return x[31:0];
  endfunction

  function automatic logic [31:0] ref_calc(input logic [1:0] op,
      input logic [31:0] a, input logic [31:0] b, output bit s);
    longint la, lb, sec;
    bit s1, s2;
    logic [31:0] r;
    la = longint'($signed(a));
    lb = longint'($signed(b));
    s1 = 1'b0;
    sec = lb;
    if (op[1]) sec = longint'($signed(sat32(lb + lb, s1)));
    if (op[0]) r = sat32(la - sec, s2);
    else       r = sat32(la + sec, s2);
    s = s1 | s2;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit c, input logic [1:0] op,
      input logic [31:0] a, input logic [31:0] b,
      input string rtag, input string ftag);
    bit s;
    logic [31:0] r;
    @(negedge clk_i);
    valid_i = v; clr_i = c; op_i = op; opa_i = a; opb_i = b;
    r = ref_calc(op, a, b, s);
    if (v) exp_res = r;
    if (c)      exp_flag = v & s;
    else if (v) exp_flag = exp_flag | s;
    @(posedge clk_i);
    #1;
    check(res_o == exp_res, rtag, res_o, exp_res);
    check(status_o == (32'(exp_flag) << 27), ftag, status_o, 32'(exp_flag) << 27);
  endtask

  task automatic clear();
    step(1'b0, 1'b1, 2'b00, 32'h0, 32'h0, "R8", "R7");
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h7FFFFFFF;
      1: return 32'h80000000;
      2: return 32'h40000000;
      3: return 32'hC0000000;
      4: return 32'h00000001;
      5: return 32'hFFFFFFFF;
      default: return $urandom;
    endcase
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    repeat (3) @(posedge clk_i);
    #1;
    check(res_o == 32'h0, "R9", res_o, 32'h0);
    check(status_o == 32'h0, "R9", status_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1
    step(1, 0, 2'b00, 32'd5, 32'hFFFFFFFD, "R1", "R5");
    step(1, 0, 2'b00, 32'h7FFFFFFF, 32'h1, "R1", "R5");
    clear();
    step(1, 0, 2'b00, 32'h80000000, 32'hFFFFFFFF, "R1", "R5");
    clear();
    step(1, 0, 2'b00, 32'h7FFFFFFE, 32'h1, "R1", "R5");
    // R2
    step(1, 0, 2'b01, 32'h80000000, 32'h1, "R2", "R5");
    clear();
    step(1, 0, 2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, "R2", "R5");
    clear();
    step(1, 0, 2'b01, 32'h0, 32'h80000000, "R2", "R5");
    clear();
    step(1, 0, 2'b01, 32'h0, 32'h7FFFFFFF, "R2", "R5");
    // R3: doubling step clamps, final in range, flag must still rise (R5)
    step(1, 0, 2'b10, 32'h80000000, 32'h40000000, "R3", "R5");
    clear();
    step(1, 0, 2'b10, 32'd10, 32'd3, "R3", "R5");
    step(1, 0, 2'b10, 32'h7FFFFFFF, 32'h1, "R3", "R5");
    clear();
    // R4: exact doubled minimum, then final clamp
    step(1, 0, 2'b11, 32'h0, 32'hC0000000, "R4", "R5");
    clear();
    step(1, 0, 2'b11, 32'h7FFFFFFF, 32'h80000000, "R4", "R5");
    step(1, 0, 2'b11, 32'd100, 32'd7, "R4", "R6");
    step(1, 0, 2'b00, 32'd1, 32'd1, "R1", "R6");
    // R8: idle, inputs wiggle
    step(0, 0, 2'b01, 32'h7FFFFFFF, 32'h80000000, "R8", "R8");
    step(0, 0, 2'b10, 32'h12345678, 32'h9ABCDEF0, "R8", "R8");
    // R7: clear plus operation
    step(1, 1, 2'b00, 32'd2, 32'd3, "R1", "R7");
    step(1, 1, 2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, "R1", "R7");
    step(1, 1, 2'b10, 32'h0, 32'h1, "R3", "R7");

    for (int i = 0; i < 2000; i++) begin
      logic [1:0] op;
      bit v, c;
      op = 2'($urandom);
      v = ($urandom % 8) != 0;
      c = ($urandom % 16) == 0;
      step(v, c, op, pick(), pick(), v ? op_tag(op) : "R8", c ? "R7" : "R10");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule